// File: doc/BRIEF.md
# Eight-Point Fixed-Point Inverse Transform Stream Engine

This block is a coprocessor that computes a one-dimensional, eight-point inverse discrete cosine transform in fixed-point arithmetic. A processor writes coefficient words to it over an input stream and reads result words back over a separate output stream. Both streams use a valid/ready handshake, so the processor can use blocking push and pull operations.

Every transform passes through three phases. The engine first gathers eight input words. It then runs eight multiply-accumulate steps, in which eight parallel lanes each add one product per cycle. Last, it presents the eight results in index order, holding each word until the consumer takes it. Input is refused during the compute and emit phases. A synchronous reset discards a partially gathered frame.

Top module: `idct8_stream`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `in_ready` is 1 and `out_valid` is 0. Any words gathered before the reset are discarded, so the next eight accepted words form a fresh frame.
- R2: A word is accepted only on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` falls on the edge that accepts the eighth word of a frame.
- R3: Each input word carries a signed 16-bit value x[k] in bits [15:0]. Bits [31:16] have no effect on any result.
- R4: Result n (n = 0..7) is built on the sum S[n] = Σk x[k]·K[n][k]. The constants are K[n][0] = round(2^14/√2) = 11585 and, for k > 0, K[n][k] = round(2^14·cos((2n+1)kπ/16)).
- R5: Rounding: the result is floor((S[n] + 2^14) / 2^15), which is an arithmetic shift right by 15 after adding 2^14.
- R6: A rounded value above 32767 is output as 32767, and a value below −32768 is output as −32768.
- R7: Every output word is the 16-bit result sign-extended to 32 bits.
- R8: `out_valid` rises exactly 8 clock cycles after the edge that accepts the eighth input word. `in_ready` and `out_valid` are never 1 together.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R10: Exactly eight results are emitted per frame, in order n = 0 to 7. On the edge that hands over the eighth result, `out_valid` falls and `in_ready` rises.
- R11: `in_valid` and `in_data` are ignored while `in_ready` is 0. Words offered during compute or emit enter no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 32 | Input word; the coefficient is in bits [15:0] |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Engine is gathering and can take a word |
| out_data | output | 32 | Sign-extended result word |
| out_valid | output | 1 | `out_data` holds a result |
| out_ready | input | 1 | Consumer takes `out_data` |

## Verification
The assertions check the handshake on every cycle:
- the input and output sides never open together;
- the eighth-word boundary on both sides;
- the fixed 8-cycle gap between the last accepted word and the first result;
- that a result stalled by backpressure holds steady;
- the sign extension of every result.

The arithmetic itself can only be shown by the bench's scenarios. These compare every result word against sums built from cosine values computed in real arithmetic. They cover:
- impulses at each index with small and full-scale values;
- small inputs that land on either side of a rounding boundary;
- inputs aligned with the cosine signs so that the results saturate;
- pseudo-random frames.

The bench also shows three things by their effect on later results: that a reset discards a partial frame, that the upper input bits are ignored, and that input offered while the engine is busy is dropped.

// File: rtl/idct8_pkg.sv
// Shared definitions for the eight-point inverse transform engine.
// Assumes a fixed transform size of eight and 16-bit Q1.14 constants.
package idct8_pkg;

    localparam int NPTS   = 8;
    localparam int IDX_W  = $clog2(NPTS);
    localparam int COEF_W = 16;

    typedef enum logic [1:0] {
        PH_GATHER  = 2'd0,
        PH_COMPUTE = 2'd1,
        PH_EMIT    = 2'd2
    } phase_t;

    // Q1.14 value of cos(m*pi/16) for m in 0..8
    function automatic logic signed [COEF_W-1:0] cos_q14(input int m);
        case (m)
            0:       return 16'sd16384;
            1:       return 16'sd16069;
            2:       return 16'sd15137;
            3:       return 16'sd13623;
            4:       return 16'sd11585;
            5:       return 16'sd9102;
            6:       return 16'sd6270;
            7:       return 16'sd3196;
            default: return 16'sd0;
        endcase
    endfunction

    // Transform constant for output row and input column, folded by symmetry
    function automatic logic signed [COEF_W-1:0] idct_coef(input int row, input int col);
        int m;
        if (col == 0) return 16'sd11585;
        m = ((2 * row + 1) * col) % 32;
        if (m > 16) m = 32 - m;
        if (m > 8)  return -cos_q14(16 - m);
        return cos_q14(m);
    endfunction

endpackage

// File: rtl/idct8_gather.sv
// Input buffer: stores the low DATA_W bits of each accepted word in
// arrival order and flags when the next accepted word completes a frame.
// Assumes the caller only asserts take while input is open.
module idct8_gather
    import idct8_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     take,
    input  logic [WORD_W-1:0]        word_in,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic signed [DATA_W-1:0] sample,
    output logic                     last_slot
);

    logic signed [DATA_W-1:0] slots [NPTS];
    logic [IDX_W-1:0]         fill;
    logic                     unused_hi;

    // the upper bits of the word carry nothing
    assign unused_hi = ^word_in[WORD_W-1:DATA_W];

    // count the words of the current frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill <= '0;
        else if (take)
            fill <= (fill == IDX_W'(NPTS - 1)) ? '0 : fill + 1'b1;
    end

    // store each accepted coefficient in its slot
    always_ff @(posedge clk) begin
        if (take)
            slots[fill] <= word_in[DATA_W-1:0];
    end

    // present the slot selected by the compute step
    always_comb begin
        sample    = slots[rd_idx];
        last_slot = (fill == IDX_W'(NPTS - 1));
    end

endmodule

// File: rtl/idct8_mac_lane.sv
// One multiply-accumulate lane: owns output row LANE and adds
// x[step]*K[LANE][step] once per enabled cycle. A clear wins over enable.
module idct8_mac_lane
    import idct8_pkg::*;
#(
    parameter int LANE   = 0,
    parameter int DATA_W = 16,
    parameter int ACC_W  = 36
) (
    input  logic                     clk,
    input  logic                     clear,
    input  logic                     en,
    input  logic [IDX_W-1:0]         step,
    input  logic signed [DATA_W-1:0] x,
    output logic signed [ACC_W-1:0]  acc
);

    localparam int PROD_W = DATA_W + COEF_W;

    logic signed [COEF_W-1:0] coef;
    logic signed [PROD_W-1:0] prod;

    // select this lane's constant for the current step
    always_comb begin
        coef = idct_coef(LANE, int'(step));
        prod = x * coef;
    end

    // accumulate one product per compute cycle
    always_ff @(posedge clk) begin
        if (clear)
            acc <= '0;
        else if (en)
            acc <= acc + ACC_W'(prod);
    end

endmodule

// File: rtl/idct8_shaper.sv
// Output shaping: adds the rounding bias, shifts right arithmetically,
// saturates to DATA_W signed and sign-extends to WORD_W.
module idct8_shaper #(
    parameter int ACC_W  = 36,
    parameter int SHIFT  = 15,
    parameter int DATA_W = 16,
    parameter int WORD_W = 32
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic [WORD_W-1:0]       word_out
);

    localparam logic signed [ACC_W-1:0] BIAS = ACC_W'(1) <<< (SHIFT - 1);
    localparam logic signed [ACC_W-1:0] HI   = (ACC_W'(1) <<< (DATA_W - 1)) - 1;
    localparam logic signed [ACC_W-1:0] LO   = -HI - 1;

    logic signed [ACC_W-1:0]  scaled;
    logic signed [DATA_W-1:0] clipped;

    // round, scale and clip the accumulated sum
    always_comb begin
        scaled = (acc + BIAS) >>> SHIFT;
        if (scaled > HI)
            clipped = HI[DATA_W-1:0];
        else if (scaled < LO)
            clipped = LO[DATA_W-1:0];
        else
            clipped = scaled[DATA_W-1:0];
        word_out = {{(WORD_W - DATA_W){clipped[DATA_W-1]}}, clipped};
    end

endmodule

// File: rtl/idct8_stream.sv
// Stream-attached eight-point fixed-point inverse transform.
// Gathers eight words, runs eight parallel MAC steps, then emits eight
// results in order under valid/ready. Reset is synchronous, active low.
module idct8_stream
    import idct8_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DATA_W = 16,
    parameter int SHIFT  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);

    localparam int ACC_W = DATA_W + COEF_W + IDX_W + 1;

    phase_t                   phase;
    logic [IDX_W-1:0]         step;
    logic [IDX_W-1:0]         emit_idx;
    logic                     take;
    logic                     last_slot;
    logic                     frame_done;
    logic signed [DATA_W-1:0] sample;
    logic signed [ACC_W-1:0]  lane_acc [NPTS];

    // handshake decode from the phase
    always_comb begin
        in_ready   = (phase == PH_GATHER);
        out_valid  = (phase == PH_EMIT);
        take       = in_valid && in_ready;
        frame_done = take && last_slot;
    end

    // phase sequencing with the compute step and emit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_GATHER;
            step     <= '0;
            emit_idx <= '0;
        end else begin
            case (phase)
                PH_GATHER: begin
                    if (frame_done) begin
                        phase <= PH_COMPUTE;
                        step  <= '0;
                    end
                end
                PH_COMPUTE: begin
                    step <= step + 1'b1;
                    if (step == IDX_W'(NPTS - 1)) begin
                        phase    <= PH_EMIT;
                        emit_idx <= '0;
                    end
                end
                PH_EMIT: begin
                    if (out_ready) begin
                        emit_idx <= emit_idx + 1'b1;
                        if (emit_idx == IDX_W'(NPTS - 1))
                            phase <= PH_GATHER;
                    end
                end
                default: phase <= PH_GATHER;
            endcase
        end
    end

    idct8_gather #(
        .WORD_W (WORD_W),
        .DATA_W (DATA_W)
    ) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .word_in   (in_data),
        .rd_idx    (step),
        .sample    (sample),
        .last_slot (last_slot)
    );

    for (genvar n = 0; n < NPTS; n++) begin : g_lane
        idct8_mac_lane #(
            .LANE   (n),
            .DATA_W (DATA_W),
            .ACC_W  (ACC_W)
        ) u_lane (
            .clk   (clk),
            .clear (frame_done),
            .en    (phase == PH_COMPUTE),
            .step  (step),
            .x     (sample),
            .acc   (lane_acc[n])
        );
    end

    idct8_shaper #(
        .ACC_W  (ACC_W),
        .SHIFT  (SHIFT),
        .DATA_W (DATA_W),
        .WORD_W (WORD_W)
    ) u_shape (
        .acc      (lane_acc[emit_idx]),
        .word_out (out_data)
    );

endmodule

// File: rtl/idct8_stream_checker.sv
// Protocol checker for idct8_stream, attached by bind. Watches only the
// ports and keeps its own word and gap counters.
module idct8_stream_checker #(
    parameter int WORD_W = 32,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_ready
);

    logic [2:0] icnt;
    logic [2:0] ocnt;
    logic [3:0] gap;

    // count accepted words, results handed over and idle compute cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icnt <= '0;
            ocnt <= '0;
            gap  <= '0;
        end else begin
            if (in_valid && in_ready)   icnt <= icnt + 1'b1;
            if (out_valid && out_ready) ocnt <= ocnt + 1'b1;
            gap <= (!in_ready && !out_valid) ? gap + 1'b1 : '0;
        end
    end

    // R2: input closes only on the edge that takes the eighth word
    a_r2_close_on_eighth: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(in_valid) && $past(icnt) == 3'd7);

    // R8: the two sides are never open together
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R8: first result appears after exactly eight compute cycles
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> gap == 4'd8);

    // R9: a stalled result holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R7: results are sign-extended
    a_r7_sext: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data[WORD_W-1:DATA_W] == {(WORD_W - DATA_W){out_data[DATA_W-1]}});

    // R10: output closes only after the eighth handover
    a_r10_eight_out: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(out_ready) && $past(ocnt) == 3'd7 && in_ready);

endmodule

bind idct8_stream idct8_stream_checker #(
    .WORD_W (WORD_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready)
);

// File: tb/idct8_stream_test.sv
`timescale 1ns/1ps
module idct8_stream_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int xs [8];
    logic [15:0] lfsr = 16'hACE1;

    idct8_stream uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

    always #10 clk = ~clk;

    // watchdog ends a hung run as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL R10 watchdog expired actual=%0d expected<100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endfunction

    // R4 constants from real-valued cosines
    function automatic int kq(input int n, input int k);
        real c, v;
        c = (k == 0) ? $sqrt(0.5) : 1.0;
        v = 16384.0 * c * $cos((2 * n + 1) * k * 3.141592653589793 / 16.0);
        return $rtoi(v + ((v >= 0.0) ? 0.5 : -0.5));
    endfunction

    // R4/R5/R6 expected result for row n
    function automatic int ref_out(input int n);
        longint s, r;
        s = 0;
        for (int k = 0; k < 8; k++) s += longint'(xs[k]) * longint'(kq(n, k));
        r = (s + 64'sd16384) >>> 15;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    // offer one word and wait until it is taken
    task automatic push(input logic [31:0] w);
        int guard = 0;
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    // run one frame from xs; junk fills bits 31:16 (R3)
    task automatic run_frame(input logic [15:0] junk, input bit poke, input bit stall);
        int lat = 0;
        int got = 0;
        int guard = 0;
        int expv [8];
        bit held = 1'b0;
        logic [31:0] held_data = '0;
        for (int n = 0; n < 8; n++) expv[n] = ref_out(n);
        for (int i = 0; i < 8; i++) push({junk, 16'(xs[i])});
        // R11: keep offering words while the engine is busy
        in_valid = poke;
        in_data  = {~junk, 16'h7FFF};
        while (!out_valid && lat < 20) begin
            check(!in_ready, "R8", "in_ready high during compute", in_ready, 0);
            @(negedge clk);
            lat++;
        end
        check(lat == 8, "R8", "cycles to first result", lat, 8);
        while (got < 8 && guard < 200) begin
            step_lfsr();
            out_ready = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
            if (held) begin
                check(out_valid && out_data == held_data, "R9", "stalled result moved",
                      out_data, held_data);
                held = 1'b0;
            end
            if (out_valid) begin
                check(!in_ready, "R8", "in_ready high during emit", in_ready, 0);
                if (out_ready) begin
                    check($signed(out_data) == expv[got], "R4", $sformatf("result %0d", got),
                          $signed(out_data), expv[got]);
                    got++;
                end else begin
                    held = 1'b1;
                    held_data = out_data;
                end
            end
            @(negedge clk);
            guard++;
        end
        out_ready = 1'b0;
        in_valid  = 1'b0;
        check(got == 8, "R10", "results handed over", got, 8);
        check(in_ready && !out_valid, "R10", "input reopens after eighth result",
              {in_ready, out_valid}, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(in_ready && !out_valid, "R1", "reset state", {in_ready, out_valid}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !out_valid, "R1", "state after release", {in_ready, out_valid}, 2);

        // R4 impulses at every index, several magnitudes
        for (int k = 0; k < 8; k++) begin
            for (int v = 0; v < 4; v++) begin
                for (int i = 0; i < 8; i++) xs[i] = 0;
                xs[k] = (v == 0) ? 1000 : (v == 1) ? -1000 : (v == 2) ? 32767 : -32768;
                run_frame(16'(k * 4099 + v), v[0], v[1]);
            end
        end

        // R5 rounding boundaries on x0 (11585*x0 + 16384) >>> 15
        for (int v = -3; v <= 3; v++) begin
            for (int i = 0; i < 8; i++) xs[i] = 0;
            xs[0] = v;
            run_frame(16'hFFFF, 1'b0, 1'b0);
        end

        // R6 saturation: inputs aligned with row signs, both polarities
        for (int r = 0; r < 8; r += 3) begin
            for (int i = 0; i < 8; i++) xs[i] = (kq(r, i) >= 0) ? 32767 : -32768;
            run_frame(16'h8000, 1'b1, 1'b1);
            for (int i = 0; i < 8; i++) xs[i] = (kq(r, i) >= 0) ? -32768 : 32767;
            run_frame(16'h1234, 1'b0, 1'b1);
        end

        // R1 partial frame discarded by reset
        for (int i = 0; i < 5; i++) push({16'h0, 16'h4000});
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(in_ready && !out_valid, "R1", "reset mid-frame", {in_ready, out_valid}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 8; i++) xs[i] = 100 * (i + 1) - 400;
        run_frame(16'h0F0F, 1'b0, 1'b0);

        // R3/R11 pseudo-random frames with junk high bits and busy-time pokes
        for (int f = 0; f < 40; f++) begin
            for (int i = 0; i < 8; i++) begin
                step_lfsr();
                xs[i] = int'($signed(lfsr ^ 16'(f * 977 + i * 31)));
            end
            step_lfsr();
            run_frame(lfsr, f[0], f[1]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule